// File: doc/BRIEF.md
# Dual Capture/Compare Channels with Prioritised Interrupt Vector

This block sits beside a free-running or mode-controlled 16-bit timer and gives it two capture/compare channels. Each channel is set either to watch the timer count for equality with its data register, or to copy the count into its data register when its capture trigger is seen high. Either event raises the channel's interrupt flag. The timer's overflow indication raises a third flag.

A read-only vector register reports the most urgent enabled pending source as a small even code. Reading that register clears exactly the flag it reported, so an interrupt handler can read the vector repeatedly to drain the pending sources in priority order. A single interrupt request line is raised while any enabled source is pending.

The register bus is a simple single-cycle interface: writes take effect at the clock edge, read data is combinational from the address, and a read strobe of the vector address acknowledges the reported source at the edge that ends the read.

Top module: `ccv_unit`

## Requirements
- R1: After synchronous reset, every register reads 0, both channels are in compare mode, `irq_vec` is 0, `irq` is low and `cmp_hit` is 0.
- R2: Register offsets are 0 channel-1 control, 1 channel-1 data, 2 channel-2 control, 3 channel-2 data, 4 vector, 5 overflow control. In a channel control register, bit 0 is the flag, bit 4 the interrupt enable and bit 8 the mode (0 compare, 1 capture). Other bits read 0. The vector register ignores writes. The overflow control register holds the flag in bit 0 and the enable in bit 1.
- R3: In compare mode, `cmp_hit` for a channel pulses high for the one cycle in which the count first equals the data register, and the flag is set at that edge. A stretch in which the count stays equal causes exactly one pulse and one flag set.
- R4: In capture mode, a trigger sampled high at a clock edge copies the count into the data register and sets the flag. A channel in capture mode never pulses `cmp_hit`. In compare mode the trigger has no effect.
- R5: A high `tmr_ovf` at a clock edge sets the overflow flag.
- R6: `irq_vec` is 0x2 for channel 1, 0x4 for channel 2 and 0xA for overflow, with channel 1 highest and overflow lowest. Only sources whose flag and enable are both set take part, otherwise 0.
- R7: A read of the vector register returns `irq_vec` and clears only the flag it reported. Other flags stay pending.
- R8: `irq` is high exactly when `irq_vec` is non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_cnt | input | 16 | Current timer count |
| cap_trig | input | 2 | Capture trigger per channel, bit 0 is channel 1 |
| tmr_ovf | input | 1 | Timer overflow event |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| cmp_hit | output | 2 | Compare-match pulse per channel |
| irq_vec | output | 4 | Vector code of the winning source |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest situation to reach is several sources pending at once, which shows both the priority order and the rule that a vector read retires only the winner. The stimulus builds this state step by step. It sets the channel-1 flag by a register write and leaves a channel-2 capture flag pending. It then enables overflow and pulses it. Three vector reads follow, and after each one the bench inspects the remaining flags. A second difficult case is the stretched count: the count is held equal to the compare value for several cycles, as a divided timer clock would do, to confirm that one match gives one event.

// File: rtl/ccv_pkg.sv
package ccv_pkg;

    parameter int CNT_W  = 16;
    parameter int ADDR_W = 3;
    parameter int NUM_CH = 2;
    localparam int VEC_W = 4;
    localparam int NUM_SRC = NUM_CH + 1;

    // control register bit positions
    localparam int CTL_FLAG_BIT = 0;
    localparam int CTL_IE_BIT   = 4;
    localparam int CTL_MODE_BIT = 8;

    // register offsets
    localparam logic [ADDR_W-1:0] OFF_VEC = 3'd4;
    localparam logic [ADDR_W-1:0] OFF_OVF = 3'd5;

    // vector codes
    localparam logic [VEC_W-1:0] VEC_NONE = 4'h0;
    localparam logic [VEC_W-1:0] VEC_OVF  = 4'hA;

    typedef logic [CNT_W-1:0] word_t;

    typedef enum logic {
        MODE_CMP = 1'b0,
        MODE_CAP = 1'b1
    } ch_mode_e;

    typedef struct packed {
        ch_mode_e mode;
        logic     ie;
        logic     flag;
    } ch_ctl_t;

    // vector code of channel index i (0-based): 2, 4, ...
    function automatic logic [VEC_W-1:0] ch_code(input int i);
        return VEC_W'(2 * (i + 1));
    endfunction

    function automatic word_t ctl_to_word(input ch_ctl_t c);
        word_t w;
        w = '0;
        w[CTL_FLAG_BIT] = c.flag;
        w[CTL_IE_BIT]   = c.ie;
        w[CTL_MODE_BIT] = c.mode;
        return w;
    endfunction

    // register offset of channel i control / data
    function automatic logic [ADDR_W-1:0] ch_ctl_off(input int i);
        return ADDR_W'(2 * i);
    endfunction

    function automatic logic [ADDR_W-1:0] ch_dat_off(input int i);
        return ADDR_W'(2 * i + 1);
    endfunction

endpackage

// File: rtl/ccv_channel.sv
module ccv_channel
    import ccv_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  word_t   cnt,
    input  logic    trig,
    input  logic    ctl_we,
    input  logic    dat_we,
    input  word_t   wdata,
    input  logic    rd_clr,
    output ch_ctl_t ctl,
    output word_t   dat,
    output logic    hit
);

    logic match;
    logic match_q;
    logic cap_ev;

    assign match  = (cnt == dat);
    assign hit    = (ctl.mode == MODE_CMP) && match && !match_q;
    assign cap_ev = (ctl.mode == MODE_CAP) && trig;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl     <= '{mode: MODE_CMP, ie: 1'b0, flag: 1'b0};
            dat     <= '0;
            match_q <= 1'b0;
        end else begin
            match_q <= match;
            if (ctl_we) begin
                ctl.mode <= ch_mode_e'(wdata[CTL_MODE_BIT]);
                ctl.ie   <= wdata[CTL_IE_BIT];
                ctl.flag <= wdata[CTL_FLAG_BIT];
            end
            if (rd_clr) ctl.flag <= 1'b0;
            if (dat_we) dat <= wdata;
            // hardware events win over software updates
            if (cap_ev) begin
                dat      <= cnt;
                ctl.flag <= 1'b1;
            end
            if (hit) ctl.flag <= 1'b1;
        end
    end

    a_r4_capture_latch: assert property (@(posedge clk) disable iff (rst)
        (ctl.mode == MODE_CAP && trig) |=> (dat == $past(cnt) && ctl.flag));

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        hit |=> !hit);

    a_r3_flag_on_hit: assert property (@(posedge clk) disable iff (rst)
        hit |=> ctl.flag);

endmodule

// File: rtl/ccv_vector.sv
module ccv_vector
    import ccv_pkg::*;
(
    input  logic [NUM_SRC-1:0] pend,
    input  logic               rd_vec,
    output logic [VEC_W-1:0]   vec,
    output logic [NUM_SRC-1:0] clr
);

    logic [NUM_SRC-1:0] win;

    always_comb begin
        win = '0;
        vec = VEC_NONE;
        // lowest index has highest priority; scan from the bottom up
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                win    = '0;
                win[i] = 1'b1;
                vec    = (i == NUM_SRC - 1) ? VEC_OVF : ch_code(i);
            end
        end
    end

    assign clr = rd_vec ? win : '0;

    always_comb begin
        a_r7_clear_single: assert ($onehot0(clr));
    end

endmodule

// File: rtl/ccv_unit.sv
module ccv_unit
    import ccv_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] tmr_cnt,
    input  logic [1:0]  cap_trig,
    input  logic        tmr_ovf,
    input  logic [2:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic [1:0]  cmp_hit,
    output logic [3:0]  irq_vec,
    output logic        irq
);

    ch_ctl_t            ch_ctl [NUM_CH];
    word_t              ch_dat [NUM_CH];
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] clr;
    logic               ovf_flag;
    logic               ovf_ie;
    logic               rd_vec;

    assign rd_vec = bus_rd && (bus_addr == OFF_VEC);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        ccv_channel u_ch (
            .clk    (clk),
            .rst    (rst),
            .cnt    (tmr_cnt),
            .trig   (cap_trig[g]),
            .ctl_we (bus_wr && (bus_addr == ch_ctl_off(g))),
            .dat_we (bus_wr && (bus_addr == ch_dat_off(g))),
            .wdata  (bus_wdata),
            .rd_clr (clr[g]),
            .ctl    (ch_ctl[g]),
            .dat    (ch_dat[g]),
            .hit    (cmp_hit[g])
        );
        assign pend[g] = ch_ctl[g].flag && ch_ctl[g].ie;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_flag <= 1'b0;
            ovf_ie   <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == OFF_OVF) begin
                ovf_flag <= bus_wdata[0];
                ovf_ie   <= bus_wdata[1];
            end
            if (clr[NUM_SRC-1]) ovf_flag <= 1'b0;
            if (tmr_ovf) ovf_flag <= 1'b1;
        end
    end

    assign pend[NUM_SRC-1] = ovf_flag && ovf_ie;

    ccv_vector u_vec (
        .pend   (pend),
        .rd_vec (rd_vec),
        .vec    (irq_vec),
        .clr    (clr)
    );

    assign irq = (irq_vec != VEC_NONE);

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ch_ctl_off(i)) bus_rdata = ctl_to_word(ch_ctl[i]);
            if (bus_addr == ch_dat_off(i)) bus_rdata = ch_dat[i];
        end
        if (bus_addr == OFF_VEC) bus_rdata = {{(CNT_W-VEC_W){1'b0}}, irq_vec};
        if (bus_addr == OFF_OVF) bus_rdata = {{(CNT_W-2){1'b0}}, ovf_ie, ovf_flag};
    end

    a_r5_ovf_sets: assert property (@(posedge clk) disable iff (rst)
        tmr_ovf |=> ovf_flag);

    a_r6_ch1_wins: assert property (@(posedge clk) disable iff (rst)
        (ch_ctl[0].flag && ch_ctl[0].ie) |-> (irq_vec == 4'h2));

    a_r7_ovf_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_vec && irq_vec == VEC_OVF && !tmr_ovf) |=> !ovf_flag);

    a_r8_irq_has_source: assert property (@(posedge clk) disable iff (rst)
        irq |-> (pend != '0));

endmodule

// File: tb/sim_ccv_unit.sv
module sim_ccv_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] tmr_cnt = 16'h1234;
    logic [1:0]  cap_trig = 2'b00;
    logic        tmr_ovf = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic [1:0]  cmp_hit;
    logic [3:0]  irq_vec;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    ccv_unit u0 (
        .clk(clk), .rst(rst), .tmr_cnt(tmr_cnt), .cap_trig(cap_trig),
        .tmr_ovf(tmr_ovf), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cmp_hit(cmp_hit), .irq_vec(irq_vec), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // returns combinational read data; strobe ends after one edge
    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d);
            check("R1", $sformatf("reg %0d after reset", a), d, 16'h0);
        end
        check("R1", "irq_vec", {12'h0, irq_vec}, 16'h0);
        check("R1", "irq", {15'h0, irq}, 16'h0);
        check("R1", "cmp_hit", {14'h0, cmp_hit}, 16'h0);
    endtask

    task automatic t_map();
        logic [15:0] d;
        wr(3'd4, 16'hFFFF);
        rd(3'd4, d);
        check("R2", "vector ignores writes", d, 16'h0);
        wr(3'd0, 16'hFFFF);
        peek(3'd0, d);
        check("R2", "ctl keeps bits 8,4,0 only", d, 16'h0111);
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'hBEEF);
        peek(3'd1, d);
        check("R2", "data register", d, 16'hBEEF);
        wr(3'd5, 16'hFFFF);
        peek(3'd5, d);
        check("R2", "overflow ctl bits 1:0", d, 16'h0003);
        wr(3'd5, 16'h0000);
    endtask

    task automatic t_compare();
        logic [15:0] d;
        wr(3'd0, 16'h0010);
        wr(3'd1, 16'h0050);
        @(negedge clk); tmr_cnt = 16'h004F;
        #1 check("R3", "no hit before match", {14'h0, cmp_hit}, 16'h0);
        @(negedge clk); tmr_cnt = 16'h0050;
        #1 check("R3", "hit on first equal cycle", {14'h0, cmp_hit}, 16'h1);
        @(negedge clk);
        #1 check("R3", "hit lasts one cycle", {14'h0, cmp_hit}, 16'h0);
        peek(3'd0, d);
        check("R3", "flag set by match", d, 16'h0011);
        check("R8", "irq with ch1 pending", {15'h0, irq}, 16'h1);
        rd(3'd4, d);
        check("R6", "vector ch1", d, 16'h0002);
        for (int k = 0; k < 3; k++) @(negedge clk);
        peek(3'd0, d);
        check("R3", "held equal count sets no second flag", d, 16'h0010);
        check("R8", "irq low when nothing pending", {15'h0, irq}, 16'h0);
        @(negedge clk); tmr_cnt = 16'h0051;
        @(negedge clk); tmr_cnt = 16'h0050;
        #1 check("R3", "new match event pulses", {14'h0, cmp_hit}, 16'h1);
        @(negedge clk); tmr_cnt = 16'h0060;
        rd(3'd4, d);
        check("R7", "vector read on second match", d, 16'h0002);
    endtask

    task automatic t_capture();
        logic [15:0] d;
        wr(3'd2, 16'h0110);
        @(negedge clk); tmr_cnt = 16'h0ABC; cap_trig = 2'b10;
        @(negedge clk); cap_trig = 2'b00; tmr_cnt = 16'h0ABD;
        peek(3'd3, d);
        check("R4", "captured count", d, 16'h0ABC);
        peek(3'd2, d);
        check("R4", "capture flag", d, 16'h0111);
        check("R6", "vector ch2", {12'h0, irq_vec}, 16'h0004);
        @(negedge clk); tmr_cnt = 16'h0ABC;
        #1 check("R4", "no hit in capture mode", {14'h0, cmp_hit}, 16'h0);
        @(negedge clk); tmr_cnt = 16'h0777; cap_trig = 2'b01;
        @(negedge clk); cap_trig = 2'b00;
        peek(3'd1, d);
        check("R4", "trigger ignored in compare mode", d, 16'h0050);
        peek(3'd0, d);
        check("R4", "no flag from trigger in compare mode", d, 16'h0010);
    endtask

    task automatic t_priority();
        logic [15:0] d;
        wr(3'd0, 16'h0011);
        wr(3'd5, 16'h0002);
        @(negedge clk); tmr_ovf = 1'b1;
        @(negedge clk); tmr_ovf = 1'b0;
        peek(3'd5, d);
        check("R5", "overflow flag set", d, 16'h0003);
        check("R6", "ch1 wins over all", {12'h0, irq_vec}, 16'h0002);
        rd(3'd4, d);
        check("R7", "first read returns ch1", d, 16'h0002);
        peek(3'd0, d);
        check("R7", "ch1 flag cleared", d, 16'h0010);
        peek(3'd2, d);
        check("R7", "ch2 flag kept", d, 16'h0111);
        peek(3'd5, d);
        check("R7", "ovf flag kept", d, 16'h0003);
        rd(3'd4, d);
        check("R7", "second read returns ch2", d, 16'h0004);
        rd(3'd4, d);
        check("R7", "third read returns ovf", d, 16'h000A);
        check("R8", "irq low after drain", {15'h0, irq}, 16'h0);
        wr(3'd0, 16'h0001);
        check("R6", "disabled flag not in vector", {12'h0, irq_vec}, 16'h0);
        rd(3'd4, d);
        check("R7", "empty vector read", d, 16'h0);
        peek(3'd0, d);
        check("R7", "disabled flag not cleared", d, 16'h0001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_map();
        t_compare();
        t_capture();
        t_priority();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule